// File: doc/BRIEF.md
# Q31 Rounding Saturating Multiplier Unit

This execution unit carries out one fractional DSP multiply. Each issued operation takes the low 32 bits of two 64-bit source operands as signed Q31 fractions and forms their full signed product. The product is aligned to a fractional intermediate by a one-bit left shift, rounded to nearest by adding half of a result LSB, and truncated to its upper 32 bits. The 32-bit result is sign-extended to 64 bits and returned one cycle later with a valid strobe. A new operation can be issued on every cycle.

Only one operand pair overflows: -1 times -1. For that pair the unit skips rounding and returns the largest positive Q31 value. It also sets a sticky overflow flag at bit 21 of a 32-bit DSP control register. Software reads that register at any time and can write it, for example to clear the flag.

Top module: `q31_rndsat_mul`

## Requirements
- R1: Only bits 31..0 of `rs_opnd` and `rt_opnd` affect the result. Bits 63..32 of either operand have no effect.
- R2: For every operand pair except the saturating one, the result word equals bits 63..32 of (2·a·b + 2^31), with a and b the signed low words.
- R3: `rd_res[63:32]` is a copy of `rd_res[31]` in every bit.
- R4: When both low words are 0x80000000, `rd_res` becomes 0x0000_0000_7FFF_FFFF and no rounding is applied.
- R5: A saturating operation sets bit 21 of the control register. The new value is visible on `ctl_rd_data` one cycle after the operation is issued.
- R6: Bit 21 is sticky. A non-saturating operation leaves the whole control register unchanged, and only a control write can clear the bit.
- R7: When `ctl_wr_en` is high, all 32 bits of `ctl_wr_data` are loaded, and the new value reads back on `ctl_rd_data` on the next cycle.
- R8: If a control write and a saturating operation fall in the same cycle, bit 21 becomes 1 and the other 31 bits take the written data.
- R9: `out_valid` is `in_valid` delayed by one cycle. `rd_res` changes only after an issued operation and holds its value otherwise.
- R10: While `rst_n` is low, `out_valid`, `rd_res` and `ctl_rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| in_valid | input | 1 | Issues one multiply this cycle |
| rs_opnd | input | 64 | First source operand (low word used) |
| rt_opnd | input | 64 | Second source operand (low word used) |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 32 | Control register write value |
| out_valid | output | 1 | Result strobe, one cycle after issue |
| rd_res | output | 64 | Sign-extended Q31 result |
| ctl_rd_data | output | 32 | Current control register contents |

## Verification
On every cycle the assertions check the valid timing and the result hold, the forced output for the -1 by -1 pair, the flag set, the stickiness of bit 21, the control load, and the write-versus-set priority. The arithmetic itself can only be shown by the bench's scenarios. These compare each result against a wide-integer model over random operands, rounding ties in both signs, -1 by the largest positive value, zero by -1, and operands with junk in the upper halves. The same scenarios check the sign extension and the reset values.

// File: rtl/q31m_pkg.sv
`timescale 1ns/1ps
package q31m_pkg;
  localparam int unsigned OPND_W    = 64;
  localparam int unsigned FRAC_W    = 32;
  localparam int unsigned CTLREG_W  = 32;
  localparam int unsigned OVF_BIT   = 21;

  // most negative and most positive fraction for a given width
  function automatic logic [FRAC_W-1:0] q_min();
    return {1'b1, {(FRAC_W-1){1'b0}}};
  endfunction

  function automatic logic [FRAC_W-1:0] q_max();
    return {1'b0, {(FRAC_W-1){1'b1}}};
  endfunction
endpackage

// File: rtl/q31_frac_mul.sv
`timescale 1ns/1ps
module q31_frac_mul #(
  parameter int unsigned Q_W = 32
) (
  input  logic [Q_W-1:0] a_w,
  input  logic [Q_W-1:0] b_w,
  output logic [Q_W-1:0] res_w,
  output logic           sat_hit
);
  localparam int unsigned PROD_W = 2 * Q_W;
  localparam logic [Q_W-1:0]    MIN_V  = {1'b1, {(Q_W-1){1'b0}}};
  localparam logic [Q_W-1:0]    MAX_V  = {1'b0, {(Q_W-1){1'b1}}};
  localparam logic [PROD_W-1:0] HALF_V = {{(Q_W){1'b0}}, 1'b1, {(Q_W-1){1'b0}}};

  logic signed [Q_W-1:0]    a_s;
  logic signed [Q_W-1:0]    b_s;
  logic signed [PROD_W-1:0] prod;
  logic [PROD_W-1:0]        aligned;
  logic [PROD_W-1:0]        rounded;
  logic                     both_min;
  logic                     unused_low;

  always_comb begin
    a_s      = a_w;
    b_s      = b_w;
    prod     = PROD_W'(a_s) * PROD_W'(b_s);
    aligned  = {prod[PROD_W-2:0], 1'b0};
    rounded  = aligned + HALF_V;
    both_min = (a_w == MIN_V) && (b_w == MIN_V);
  end

  always_comb begin
    if (both_min) begin
      res_w = MAX_V;
    end else begin
      res_w = rounded[PROD_W-1:Q_W];
    end
    sat_hit = both_min;
  end

  assign unused_low = ^{rounded[Q_W-1:0], prod[PROD_W-1]};
endmodule

// File: rtl/q31_res_reg.sv
`timescale 1ns/1ps
module q31_res_reg #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned Q_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [Q_W-1:0]    res_w,
  output logic              out_valid,
  output logic [DATA_W-1:0] rd_res
);
  localparam int unsigned EXT_W = DATA_W - Q_W;

  logic           vld_q;
  logic           vld_nxt;
  logic [Q_W-1:0] word_q;
  logic [Q_W-1:0] word_nxt;
  logic           word_en;

  always_comb begin
    vld_nxt  = in_valid;
    word_en  = in_valid;
    word_nxt = word_en ? res_w : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q  <= vld_nxt;
      word_q <= word_nxt;
    end
  end

  assign out_valid          = vld_q;
  assign rd_res[Q_W-1:0]    = word_q;

  for (genvar gi = 0; gi < EXT_W; gi++) begin : g_sext
    assign rd_res[Q_W+gi] = word_q[Q_W-1];
  end
endmodule

// File: rtl/q31_dsp_ctl.sv
`timescale 1ns/1ps
module q31_dsp_ctl #(
  parameter int unsigned CTL_W    = 32,
  parameter int unsigned FLAG_POS = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             sat_fire,
  output logic [CTL_W-1:0] ctl_q
);
  logic [CTL_W-1:0] ctl_nxt;

  for (genvar gb = 0; gb < CTL_W; gb++) begin : g_bit
    if (gb == FLAG_POS) begin : g_sticky
      // set from the datapath overrides a software write
      always_comb begin
        if (sat_fire) begin
          ctl_nxt[gb] = 1'b1;
        end else if (wr_en) begin
          ctl_nxt[gb] = wr_data[gb];
        end else begin
          ctl_nxt[gb] = ctl_q[gb];
        end
      end
    end else begin : g_plain
      always_comb begin
        if (wr_en) begin
          ctl_nxt[gb] = wr_data[gb];
        end else begin
          ctl_nxt[gb] = ctl_q[gb];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_nxt;
    end
  end
endmodule

// File: rtl/q31_rndsat_mul.sv
`timescale 1ns/1ps
module q31_rndsat_mul #(
  parameter int unsigned DATA_W   = q31m_pkg::OPND_W,
  parameter int unsigned Q_W      = q31m_pkg::FRAC_W,
  parameter int unsigned CTL_W    = q31m_pkg::CTLREG_W,
  parameter int unsigned FLAG_POS = q31m_pkg::OVF_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] rs_opnd,
  input  logic [DATA_W-1:0] rt_opnd,
  input  logic              ctl_wr_en,
  input  logic [CTL_W-1:0]  ctl_wr_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] rd_res,
  output logic [CTL_W-1:0]  ctl_rd_data
);
  logic [Q_W-1:0] res_w;
  logic           sat_hit;
  logic           sat_fire;
  logic           unused_hi;

  q31_frac_mul #(.Q_W(Q_W)) u_mul (
    .a_w     (rs_opnd[Q_W-1:0]),
    .b_w     (rt_opnd[Q_W-1:0]),
    .res_w   (res_w),
    .sat_hit (sat_hit)
  );

  assign sat_fire  = in_valid & sat_hit;
  assign unused_hi = ^{rs_opnd[DATA_W-1:Q_W], rt_opnd[DATA_W-1:Q_W]};

  q31_res_reg #(.DATA_W(DATA_W), .Q_W(Q_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .res_w     (res_w),
    .out_valid (out_valid),
    .rd_res    (rd_res)
  );

  q31_dsp_ctl #(.CTL_W(CTL_W), .FLAG_POS(FLAG_POS)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_wr_en),
    .wr_data  (ctl_wr_data),
    .sat_fire (sat_fire),
    .ctl_q    (ctl_rd_data)
  );
endmodule

// File: rtl/q31_mul_chk.sv
`timescale 1ns/1ps
module q31_mul_chk #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned Q_W      = 32,
  parameter int unsigned CTL_W    = 32,
  parameter int unsigned FLAG_POS = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [Q_W-1:0]    rs_lo,
  input logic [Q_W-1:0]    rt_lo,
  input logic              ctl_wr_en,
  input logic [CTL_W-1:0]  ctl_wr_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] rd_res,
  input logic [CTL_W-1:0]  ctl_rd_data
);
  localparam logic [Q_W-1:0]    MIN_V = {1'b1, {(Q_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] SAT_OUT = DATA_W'({1'b0, {(Q_W-1){1'b1}}});

  logic sat_in;
  assign sat_in = in_valid && (rs_lo == MIN_V) && (rt_lo == MIN_V);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(rd_res));  // R9
  AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    sat_in |=> (rd_res == SAT_OUT));  // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sat_in |=> ctl_rd_data[FLAG_POS]);  // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_data[FLAG_POS] && !ctl_wr_en) |=> ctl_rd_data[FLAG_POS]);  // R6
  AST_CTL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr_en && !sat_in) |=> $stable(ctl_rd_data));  // R6
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && !sat_in) |=> (ctl_rd_data == $past(ctl_wr_data)));  // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && sat_in) |=> (ctl_rd_data == ($past(ctl_wr_data) | (CTL_W'(1) << FLAG_POS))));  // R8
endmodule

bind q31_rndsat_mul q31_mul_chk #(
  .DATA_W(DATA_W), .Q_W(Q_W), .CTL_W(CTL_W), .FLAG_POS(FLAG_POS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .rs_lo       (rs_opnd[Q_W-1:0]),
  .rt_lo       (rt_opnd[Q_W-1:0]),
  .ctl_wr_en   (ctl_wr_en),
  .ctl_wr_data (ctl_wr_data),
  .out_valid   (out_valid),
  .rd_res      (rd_res),
  .ctl_rd_data (ctl_rd_data)
);

// File: tb/sim_q31_rndsat_mul.sv
`timescale 1ns/1ps
module sim_q31_rndsat_mul;
  typedef struct {
    logic [63:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] rs_opnd;
  logic [63:0] rt_opnd;
  logic        ctl_wr_en;
  logic [31:0] ctl_wr_data;
  logic        out_valid;
  logic [63:0] rd_res;
  logic [31:0] ctl_rd_data;

  int   total = 0;
  int   bad   = 0;
  exp_t exp_q[$];
  logic [63:0] last_rd;
  logic        mon_on = 1'b0;

  always #2.5 clk = ~clk;

  q31_rndsat_mul u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .rs_opnd(rs_opnd), .rt_opnd(rt_opnd),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .out_valid(out_valid), .rd_res(rd_res), .ctl_rd_data(ctl_rd_data)
  );

  function automatic logic [63:0] ref_mul(logic [63:0] a, logic [63:0] b);
    logic signed [127:0] pa;
    logic signed [127:0] pb;
    logic signed [127:0] t;
    logic [31:0] r;
    pa = {{96{a[31]}}, a[31:0]};
    pb = {{96{b[31]}}, b[31:0]};
    if (a[31:0] == 32'h8000_0000 && b[31:0] == 32'h8000_0000) begin
      r = 32'h7FFF_FFFF;
    end else begin
      t = pa * pb * 2 + 128'sd2147483648;
      r = t[63:32];
    end
    return {{32{r[31]}}, r};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [63:0] a, logic [63:0] b, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    rs_opnd  = a;
    rt_opnd  = b;
    e.val = ref_mul(a, b);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      ctl_wr_en = 1'b0;
      rs_opnd   = {$urandom, $urandom};
      rt_opnd   = {$urandom, $urandom};
    end
  endtask

  task automatic drain();
    idle(1);
    while (exp_q.size() != 0) idle(1);
  endtask

  task automatic ctl_write(logic [31:0] d);
    @(negedge clk);
    in_valid    = 1'b0;
    ctl_wr_en   = 1'b1;
    ctl_wr_data = d;
    idle(1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R9: actual=unexpected result expected=none");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.tag, rd_res, e.val);
          check("R3 sign extension", rd_res[63:32], {32{rd_res[31]}});
        end
        last_rd = rd_res;
      end else begin
        check("R9 hold while idle", rd_res, last_rd);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; ctl_wr_en = 1'b0;
    ctl_wr_data = '0; rs_opnd = '0; rt_opnd = '0;
    repeat (3) @(negedge clk);
    check("R10 out_valid in reset", 64'(out_valid), 64'd0);
    check("R10 rd_res in reset", rd_res, 64'd0);
    check("R10 ctl in reset", 64'(ctl_rd_data), 64'd0);
    last_rd = 64'd0;
    rst_n  = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // corner cases
    issue(64'h0000_0000_4000_0000, 64'h0000_0000_0000_0001, "R2 positive tie");
    issue(64'h0000_0000_4000_0000, 64'h0000_0000_FFFF_FFFF, "R2 negative tie");
    issue(64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, "R2 min times max");
    issue(64'h0000_0000_0000_0000, 64'h0000_0000_8000_0000, "R2 zero times min");
    issue(64'h0000_0000_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, "R2 max times max");
    issue(64'h0000_0000_C000_0000, 64'h0000_0000_4000_0000, "R2 -0.5 times 0.5");
    issue(64'hDEAD_BEEF_4000_0000, 64'h1234_5678_2000_0000, "R1 junk upper halves");
    issue(64'hFFFF_FFFF_0000_0003, 64'h0000_0001_0000_0005, "R1 junk upper, small");
    drain();
    check("R6 no flag from normal ops", 64'(ctl_rd_data), 64'd0);

    // saturation and flag
    issue(64'h5555_5555_8000_0000, 64'hAAAA_AAAA_8000_0000, "R4 min times min");
    idle(1);
    check("R5 flag set", 64'(ctl_rd_data), 64'h0020_0000);
    issue(64'h0000_0000_1234_5678, 64'h0000_0000_8765_4321, "R2 after sat");
    idle(1);
    check("R6 flag sticky", 64'(ctl_rd_data), 64'h0020_0000);
    drain();
    ctl_write(32'h0000_0000);
    check("R6 flag cleared by write", 64'(ctl_rd_data), 64'd0);
    ctl_write(32'h1234_5678);
    check("R7 control readback", 64'(ctl_rd_data), 64'h1234_5678);
    ctl_write(32'hFFDF_FFFF);
    check("R7 control readback all but flag", 64'(ctl_rd_data), 64'hFFDF_FFFF);

    // write and saturation in the same cycle
    begin
      exp_t e;
      @(negedge clk);
      ctl_wr_en   = 1'b1;
      ctl_wr_data = 32'h0000_0001;
      in_valid    = 1'b1;
      rs_opnd     = 64'h0000_0000_8000_0000;
      rt_opnd     = 64'h0000_0000_8000_0000;
      e.val = 64'h0000_0000_7FFF_FFFF;
      e.tag = "R4 sat with write";
      exp_q.push_back(e);
    end
    idle(1);
    check("R8 set wins over write", 64'(ctl_rd_data), 64'h0020_0001);
    drain();
    ctl_write(32'h0000_0000);

    // random traffic with gaps
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(3) == 0) begin
        idle($urandom_range(3) + 1);
      end else begin
        issue({$urandom, $urandom}, {$urandom, $urandom}, "R2 random");
      end
    end
    drain();
    idle(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule